// File: doc/BRIEF.md
# Translation Access Fault Checker

This block sits behind the translation lookaside array of a load/store or fetch pipeline. Each cycle it may accept one translation request: the virtual address, the access size, the write flag, the privilege state, the hypervisor state, the address-mask state and pre-decoded address-space class flags. It also receives the attributes of the array entry that matched, or a miss indication. One cycle later it returns a response. The response is either a physical address with an uncacheable flag, or a single fault code chosen by a fixed priority order. It also carries the values to load into the fault status and tag-access registers, each with its own load strobe.

The block folds several steps into one registered stage. It screens alignment, truncates the address under address masking and rejects the unimplemented address hole. It ranks the page-attribute faults after a hit and merges the physical address using the page-size code. Hypervisor implicit accesses bypass translation entirely.

Top module: `xlat_fault_chk`

## Requirements
- R1: A request with `req_valid` high yields `rsp_valid` high for exactly the next cycle. A cycle without a request yields `rsp_valid` low, and every response output is zero in that cycle. Fault codes are: 0 none, 1 misaligned, 2 address out of range, 3 real-translation miss, 4 fast translation miss, 5 privilege violation, 6 write protection, 7 nofault page accessed by a normal class, 8 side-effect page accessed by a nofault class.
- R2: When `req_hpriv` and `req_implicit` are both high, no fault is raised and translation is skipped. The response address is the low 40 bits of the raw virtual address, `rsp_uncache` is 0, and neither register load strobe fires.
- R3: Otherwise, a request whose address is not a multiple of 2^`req_size` bytes (`req_size` 0..3 means 1, 2, 4, 8 bytes) yields code 1. This fault outranks all others.
- R4: With `req_amask` high, the effective address is the virtual address with bits 63:32 cleared. An aligned effective address in the range 0x0000_8000_0000_0000 to 0xFFFF_7FFF_FFFF_FFFF inclusive yields code 2.
- R5: A screened request with `ent_hit` low yields code 3 when `asi_real` is high and code 4 otherwise.
- R6: On codes 3 to 8, `tag_we` pulses and `tag_val` holds effective-address bits 63:13 in bits 63:13 and `req_ctx` in bits 12:0. For all other responses `tag_we` is 0.
- R7: After a hit, the faults rank in this order. A privileged page with `req_priv` low gives code 5. Then a write to a non-writable page gives code 6. Then a nofault page with `asi_nofault` low gives code 7. Then a side-effect page with `asi_nofault` high gives code 8.
- R8: A fault-free hit returns the entry address with its low S bits replaced by the effective address's low S bits. S is 13 + 3 × min(`ent_psz`, 5). A faulting response returns address 0.
- R9: `rsp_uncache` is high only for a fault-free hit on a side-effect page.
- R10: On codes 1, 2 and 5 to 8, `fsr_we` pulses and `fsr_val` is {side bit, write flag, code}. The side bit is `ent_side_effect` for codes 5 to 8 and 0 for codes 1 and 2. Otherwise `fsr_we` is 0.
- R11: While `rst_n` is low, and until the first request, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_va | input | 64 | Virtual address |
| req_size | input | 2 | Log2 of access size in bytes |
| req_write | input | 1 | Store access |
| req_priv | input | 1 | Privileged mode |
| req_hpriv | input | 1 | Hypervisor mode |
| req_amask | input | 1 | 32-bit address masking enabled |
| req_implicit | input | 1 | Access uses the implicit address space |
| req_ctx | input | 13 | Context number |
| asi_real | input | 1 | Access is a real (untranslated-tag) access |
| asi_nofault | input | 1 | Access uses a nofault address-space class |
| ent_hit | input | 1 | A valid entry matched |
| ent_pa | input | 40 | Matched entry physical address |
| ent_psz | input | 3 | Matched entry page-size code |
| ent_priv | input | 1 | Page requires privilege |
| ent_writable | input | 1 | Page is writable |
| ent_nofault | input | 1 | Page is nofault-only |
| ent_side_effect | input | 1 | Page has side effects |
| rsp_valid | output | 1 | Response valid pulse |
| rsp_fault | output | 4 | Fault code, 0 = none |
| rsp_pa | output | 40 | Physical address |
| rsp_uncache | output | 1 | Access must bypass caches |
| tag_we | output | 1 | Load strobe for tag-access register |
| tag_val | output | 64 | Tag-access register value |
| fsr_we | output | 1 | Load strobe for fault status register |
| fsr_val | output | 6 | Fault status value |

## Verification
The assertions check several properties on every cycle. The response valid tracks the request one cycle later. Bypass never faults. Misalignment always wins when not bypassed. Uncacheable appears only on fault-free responses. The two load strobes fire only for their own classes of fault. Only the bench scenarios show the exact ladder order between simultaneous page-attribute faults, the hole boundaries with and without address masking, the merged physical address for each page-size code, and the contents of the tag and status values. The bench compares these against its own model across random and directed requests.

// File: rtl/xfc_pkg.sv
package xfc_pkg;

  typedef enum logic [3:0] {
    FC_NONE      = 4'd0,
    FC_MISALIGN  = 4'd1,
    FC_VA_RANGE  = 4'd2,
    FC_REAL_MISS = 4'd3,
    FC_FAST_MISS = 4'd4,
    FC_PRIV      = 4'd5,
    FC_PROT      = 4'd6,
    FC_NF_PAGE   = 4'd7,
    FC_SE_NF     = 4'd8
  } fcode_e;

  typedef struct packed {
    logic hit;
    logic priv;
    logic writable;
    logic nofault;
    logic side_effect;
  } ent_attr_t;

endpackage

// File: rtl/xfc_va_screen.sv
module xfc_va_screen #(
  parameter int VA_W = 64,
  parameter int AMASK_W = 32,
  parameter logic [VA_W-1:0] HOLE_LO = 64'h0000_8000_0000_0000,
  parameter logic [VA_W-1:0] HOLE_HI = 64'hFFFF_7FFF_FFFF_FFFF
) (
  input  logic [VA_W-1:0] va,
  input  logic [1:0]      size,
  input  logic            amask,
  output logic [VA_W-1:0] va_eff,
  output logic            misalign,
  output logic            out_of_range
);

  function automatic logic [7:0] size_low_mask(input logic [1:0] s);
    return (8'd1 << s) - 8'd1;
  endfunction

  assign misalign = (va[7:0] & size_low_mask(size)) != 8'd0;

  generate
    if (AMASK_W < VA_W) begin : g_trunc
      assign va_eff = amask ? {{(VA_W-AMASK_W){1'b0}}, va[AMASK_W-1:0]} : va;
    end else begin : g_pass
      assign va_eff = va;
    end
  endgenerate

  assign out_of_range = (va_eff >= HOLE_LO) && (va_eff <= HOLE_HI);

endmodule

// File: rtl/xfc_attr_ladder.sv
module xfc_attr_ladder
  import xfc_pkg::*;
(
  input  ent_attr_t ent,
  input  logic      req_priv,
  input  logic      req_write,
  input  logic      asi_real,
  input  logic      asi_nofault,
  output fcode_e    code
);

  always_comb begin
    if (!ent.hit)
      code = asi_real ? FC_REAL_MISS : FC_FAST_MISS;
    else if (ent.priv && !req_priv)
      code = FC_PRIV;
    else if (req_write && !ent.writable)
      code = FC_PROT;
    else if (ent.nofault && !asi_nofault)
      code = FC_NF_PAGE;
    else if (ent.side_effect && asi_nofault)
      code = FC_SE_NF;
    else
      code = FC_NONE;
  end

endmodule

// File: rtl/xfc_pa_merge.sv
module xfc_pa_merge #(
  parameter int PA_W = 40,
  parameter int PG_SHIFT_MIN = 13,
  parameter int PG_STEP = 3,
  parameter int PSZ_MAX = 5
) (
  input  logic [PA_W-1:0] ent_pa,
  input  logic [PA_W-1:0] va_low,
  input  logic [2:0]      psz,
  output logic [PA_W-1:0] pa
);

  function automatic int page_shift(input logic [2:0] code);
    int c;
    c = int'(code);
    if (c > PSZ_MAX) c = PSZ_MAX;
    return PG_SHIFT_MIN + PG_STEP * c;
  endfunction

  logic [PA_W-1:0] off_mask;

  assign off_mask = ~({PA_W{1'b1}} << page_shift(psz));
  assign pa = (ent_pa & ~off_mask) | (va_low & off_mask);

endmodule

// File: rtl/xlat_fault_chk.sv
module xlat_fault_chk
  import xfc_pkg::*;
#(
  parameter int VA_W = 64,
  parameter int PA_W = 40,
  parameter int AMASK_W = 32,
  parameter int PG_SHIFT_MIN = 13,
  parameter int PG_STEP = 3,
  parameter int PSZ_MAX = 5,
  parameter logic [VA_W-1:0] HOLE_LO = 64'h0000_8000_0000_0000,
  parameter logic [VA_W-1:0] HOLE_HI = 64'hFFFF_7FFF_FFFF_FFFF
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic [VA_W-1:0]         req_va,
  input  logic [1:0]              req_size,
  input  logic                    req_write,
  input  logic                    req_priv,
  input  logic                    req_hpriv,
  input  logic                    req_amask,
  input  logic                    req_implicit,
  input  logic [PG_SHIFT_MIN-1:0] req_ctx,
  input  logic                    asi_real,
  input  logic                    asi_nofault,
  input  logic                    ent_hit,
  input  logic [PA_W-1:0]         ent_pa,
  input  logic [2:0]              ent_psz,
  input  logic                    ent_priv,
  input  logic                    ent_writable,
  input  logic                    ent_nofault,
  input  logic                    ent_side_effect,
  output logic                    rsp_valid,
  output logic [3:0]              rsp_fault,
  output logic [PA_W-1:0]         rsp_pa,
  output logic                    rsp_uncache,
  output logic                    tag_we,
  output logic [VA_W-1:0]         tag_val,
  output logic                    fsr_we,
  output logic [5:0]              fsr_val
);

  localparam int CTX_W = PG_SHIFT_MIN;

  // named internal events
  logic [VA_W-1:0] va_eff;
  logic            ev_misalign;
  logic            ev_range;
  logic            ev_bypass;
  fcode_e          ladder_code;
  logic [PA_W-1:0] merged_pa;
  ent_attr_t       attr;

  assign attr = '{hit: ent_hit, priv: ent_priv, writable: ent_writable,
                  nofault: ent_nofault, side_effect: ent_side_effect};
  assign ev_bypass = req_hpriv && req_implicit;

  xfc_va_screen #(
    .VA_W(VA_W), .AMASK_W(AMASK_W), .HOLE_LO(HOLE_LO), .HOLE_HI(HOLE_HI)
  ) u_screen (
    .va(req_va), .size(req_size), .amask(req_amask),
    .va_eff(va_eff), .misalign(ev_misalign), .out_of_range(ev_range)
  );

  xfc_attr_ladder u_ladder (
    .ent(attr), .req_priv(req_priv), .req_write(req_write),
    .asi_real(asi_real), .asi_nofault(asi_nofault), .code(ladder_code)
  );

  xfc_pa_merge #(
    .PA_W(PA_W), .PG_SHIFT_MIN(PG_SHIFT_MIN), .PG_STEP(PG_STEP), .PSZ_MAX(PSZ_MAX)
  ) u_merge (
    .ent_pa(ent_pa), .va_low(va_eff[PA_W-1:0]), .psz(ent_psz), .pa(merged_pa)
  );

  // next-state selection
  fcode_e          n_code;
  logic [PA_W-1:0] n_pa;
  logic            n_unc, n_twe, n_fwe, n_side;

  always_comb begin
    n_code = FC_NONE;
    n_pa   = '0;
    n_unc  = 1'b0;
    n_twe  = 1'b0;
    n_fwe  = 1'b0;
    n_side = 1'b0;
    if (ev_bypass) begin
      n_pa = req_va[PA_W-1:0];
    end else if (ev_misalign) begin
      n_code = FC_MISALIGN;
      n_fwe  = 1'b1;
    end else if (ev_range) begin
      n_code = FC_VA_RANGE;
      n_fwe  = 1'b1;
    end else begin
      n_code = ladder_code;
      case (ladder_code)
        FC_NONE: begin
          n_pa  = merged_pa;
          n_unc = ent_side_effect;
        end
        FC_REAL_MISS, FC_FAST_MISS: n_twe = 1'b1;
        default: begin
          n_twe  = 1'b1;
          n_fwe  = 1'b1;
          n_side = ent_side_effect;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !req_valid) begin
      rsp_valid   <= 1'b0;
      rsp_fault   <= 4'd0;
      rsp_pa      <= '0;
      rsp_uncache <= 1'b0;
      tag_we      <= 1'b0;
      tag_val     <= '0;
      fsr_we      <= 1'b0;
      fsr_val     <= '0;
    end else begin
      rsp_valid   <= 1'b1;
      rsp_fault   <= n_code;
      rsp_pa      <= n_pa;
      rsp_uncache <= n_unc;
      tag_we      <= n_twe;
      tag_val     <= n_twe ? {va_eff[VA_W-1:CTX_W], req_ctx} : '0;
      fsr_we      <= n_fwe;
      fsr_val     <= n_fwe ? {n_side, req_write, n_code} : 6'd0;
    end
  end

  // R1
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  // R1
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && rsp_fault == 4'd0 && !tag_we && !fsr_we));
  // R2
  bypass_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_hpriv && req_implicit) |=> (rsp_fault == 4'd0 && !rsp_uncache && !tag_we && !fsr_we));
  // R3
  misalign_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !(req_hpriv && req_implicit) && ((req_va[2:0] & ((3'd1 << req_size) - 3'd1)) != 3'd0))
      |=> rsp_fault == 4'd1);
  // R9
  uncache_only_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_uncache |-> (rsp_valid && rsp_fault == 4'd0));
  // R6
  tag_load_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tag_we |-> (rsp_fault >= 4'd3 && rsp_fault <= 4'd8));
  // R10
  fsr_load_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fsr_we |-> (rsp_fault == 4'd1 || rsp_fault == 4'd2 || (rsp_fault >= 4'd5 && rsp_fault <= 4'd8)));

endmodule

// File: tb/test_xlat_fault_chk.sv
module test_xlat_fault_chk;

  localparam int CLK_PERIOD = 10;
  localparam int N_RANDOM   = 400;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [63:0] req_va = '0;
  logic [1:0]  req_size = '0;
  logic        req_write = 1'b0, req_priv = 1'b0, req_hpriv = 1'b0;
  logic        req_amask = 1'b0, req_implicit = 1'b0;
  logic [12:0] req_ctx = '0;
  logic        asi_real = 1'b0, asi_nofault = 1'b0;
  logic        ent_hit = 1'b0;
  logic [39:0] ent_pa = '0;
  logic [2:0]  ent_psz = '0;
  logic        ent_priv = 1'b0, ent_writable = 1'b0, ent_nofault = 1'b0, ent_side_effect = 1'b0;

  logic        rsp_valid;
  logic [3:0]  rsp_fault;
  logic [39:0] rsp_pa;
  logic        rsp_uncache, tag_we, fsr_we;
  logic [63:0] tag_val;
  logic [5:0]  fsr_val;

  int vectors = 0;
  int miscompares = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xlat_fault_chk i_xlat_fault_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
    .req_size(req_size), .req_write(req_write), .req_priv(req_priv),
    .req_hpriv(req_hpriv), .req_amask(req_amask), .req_implicit(req_implicit),
    .req_ctx(req_ctx), .asi_real(asi_real), .asi_nofault(asi_nofault),
    .ent_hit(ent_hit), .ent_pa(ent_pa), .ent_psz(ent_psz), .ent_priv(ent_priv),
    .ent_writable(ent_writable), .ent_nofault(ent_nofault),
    .ent_side_effect(ent_side_effect), .rsp_valid(rsp_valid),
    .rsp_fault(rsp_fault), .rsp_pa(rsp_pa), .rsp_uncache(rsp_uncache),
    .tag_we(tag_we), .tag_val(tag_val), .fsr_we(fsr_we), .fsr_val(fsr_val)
  );

  // expected response, written from the requirements
  logic        e_valid;
  logic [3:0]  e_code;
  logic [39:0] e_pa;
  logic        e_unc, e_twe, e_fwe;
  logic [63:0] e_tag;
  logic [5:0]  e_fsr;

  function automatic string req_of(input logic [3:0] c, input logic v);
    if (!v) return "R1";
    case (c)
      4'd0: return "R8";
      4'd1: return "R3";
      4'd2: return "R4";
      4'd3, 4'd4: return "R5";
      default: return "R7";
    endcase
  endfunction

  task automatic model();
    logic [63:0] vm;
    logic [63:0] pgbytes;
    int          c;
    e_valid = req_valid; e_code = 0; e_pa = 0; e_unc = 0;
    e_twe = 0; e_fwe = 0; e_tag = 0; e_fsr = 0;
    if (!req_valid) return;
    vm = req_amask ? (req_va & 64'h0000_0000_FFFF_FFFF) : req_va;
    if (req_hpriv && req_implicit) begin
      e_pa = req_va[39:0];
      return;
    end
    if ((req_va % (64'd1 << req_size)) != 0) e_code = 4'd1;
    else if (vm >= 64'h0000_8000_0000_0000 && vm <= 64'hFFFF_7FFF_FFFF_FFFF) e_code = 4'd2;
    else if (!ent_hit) e_code = asi_real ? 4'd3 : 4'd4;
    else if (!req_priv && ent_priv) e_code = 4'd5;
    else if (!ent_writable && req_write) e_code = 4'd6;
    else if (!asi_nofault && ent_nofault) e_code = 4'd7;
    else if (asi_nofault && ent_side_effect) e_code = 4'd8;
    if (e_code == 4'd0) begin
      c = (ent_psz > 3'd5) ? 5 : int'(ent_psz);
      pgbytes = 64'd1 << (13 + 3 * c);
      e_pa = 40'({24'd0, ent_pa} - ({24'd0, ent_pa} % pgbytes) + (vm % pgbytes));
      e_unc = ent_side_effect;
    end
    if (e_code >= 4'd3) begin
      e_twe = 1;
      e_tag = {vm[63:13], req_ctx};
    end
    if (e_code == 4'd1 || e_code == 4'd2 || e_code >= 4'd5) begin
      e_fwe = 1;
      e_fsr = {(e_code >= 4'd5) ? ent_side_effect : 1'b0, req_write, e_code};
    end
  endtask

  task automatic compare(input string tag);
    vectors++;
    if (rsp_valid !== e_valid || rsp_fault !== e_code || rsp_pa !== e_pa ||
        rsp_uncache !== e_unc || tag_we !== e_twe || tag_val !== e_tag ||
        fsr_we !== e_fwe || fsr_val !== e_fsr) begin
      miscompares++;
      $display("FAIL %s [%s] got v=%0b c=%0d pa=%h unc=%0b twe=%0b tag=%h fwe=%0b fsr=%h exp v=%0b c=%0d pa=%h unc=%0b twe=%0b tag=%h fwe=%0b fsr=%h",
               tag, req_of(e_code, e_valid), rsp_valid, rsp_fault, rsp_pa, rsp_uncache, tag_we, tag_val,
               fsr_we, fsr_val, e_valid, e_code, e_pa, e_unc, e_twe, e_tag, e_fwe, e_fsr);
    end
  endtask

  // inputs are set just after a falling edge; response checked one cycle later
  task automatic apply(input string tag);
    model();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic base_hit();
    req_valid = 1; req_va = 64'h0000_0000_1234_5678; req_size = 2'd3;
    req_write = 0; req_priv = 1; req_hpriv = 0; req_amask = 0; req_implicit = 0;
    req_ctx = 13'h0A5; asi_real = 0; asi_nofault = 0;
    ent_hit = 1; ent_pa = 40'hAB_CDEF_0000; ent_psz = 0;
    ent_priv = 0; ent_writable = 1; ent_nofault = 0; ent_side_effect = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // R11: reset state
    model();
    e_valid = 0;
    compare("R11 reset");
    rst_n = 1;
    @(negedge clk);
    compare("R11 after reset, no request");

    // R8 plain hit, 8K page
    base_hit(); req_va = 64'h0000_0000_1234_5670; apply("R8 8K merge");
    // R8 each page code, including clamp above 5
    for (int p = 0; p < 8; p++) begin
      base_hit(); req_va = 64'h0000_0000_7FFF_FFF8; ent_pa = 40'hFF_FFFF_FFFF;
      ent_psz = 3'(p); apply("R8 page size code");
    end
    // R2 bypass, even misaligned and in hole
    base_hit(); req_hpriv = 1; req_implicit = 1; req_va = 64'h1234_5678_9ABC_DEF3; ent_hit = 0;
    apply("R2 bypass");
    // R3 misaligned beats miss and hole
    base_hit(); req_va = 64'h0001_0000_0000_0002; req_size = 2'd2; ent_hit = 0; apply("R3 misalign");
    base_hit(); req_va = 64'h0000_0000_0000_0001; req_size = 2'd0; apply("R3 byte always aligned");
    // R4 hole edges
    base_hit(); req_va = 64'h0000_8000_0000_0000; apply("R4 hole low edge");
    base_hit(); req_va = 64'hFFFF_7FFF_FFFF_FFF8; apply("R4 hole high edge");
    base_hit(); req_va = 64'h0000_7FFF_FFFF_FFF8; apply("R4 below hole");
    base_hit(); req_va = 64'hFFFF_8000_0000_0000; apply("R4 above hole");
    base_hit(); req_va = 64'h0000_8000_0000_0000; req_amask = 1; apply("R4 masked out of hole");
    // R5 misses
    base_hit(); ent_hit = 0; asi_real = 1; apply("R5 real miss");
    base_hit(); ent_hit = 0; asi_real = 0; req_ctx = 13'h1FFF; apply("R5 R6 fast miss tag");
    // R7 ladder ranking
    base_hit(); req_priv = 0; ent_priv = 1; req_write = 1; ent_writable = 0; ent_nofault = 1; apply("R7 priv first");
    base_hit(); req_write = 1; ent_writable = 0; ent_nofault = 1; ent_side_effect = 1; apply("R7 R10 protection");
    base_hit(); ent_nofault = 1; ent_side_effect = 1; apply("R7 nofault page");
    base_hit(); asi_nofault = 1; ent_side_effect = 1; apply("R7 side effect nofault");
    // R9 uncacheable
    base_hit(); ent_side_effect = 1; apply("R9 uncacheable");
    // R1 idle cycle
    req_valid = 0; apply("R1 idle");

    for (int n = 0; n < N_RANDOM; n++) begin
      int mode;
      req_valid = ($urandom % 8) != 0;
      mode = $urandom % 3;
      req_va = {$urandom, $urandom};
      if (mode == 0) req_va[63:47] = '0;
      else if (mode == 1) req_va[63:47] = '1;
      if (($urandom % 2) != 0) req_va[2:0] = 3'd0;
      req_size = 2'($urandom); req_write = 1'($urandom); req_priv = 1'($urandom);
      req_hpriv = ($urandom % 4) == 0; req_implicit = 1'($urandom);
      req_amask = ($urandom % 4) == 0; req_ctx = 13'($urandom);
      asi_real = 1'($urandom); asi_nofault = ($urandom % 3) == 0;
      ent_hit = ($urandom % 4) != 0; ent_pa = {8'($urandom), $urandom};
      ent_psz = 3'($urandom); ent_priv = ($urandom % 4) == 0;
      ent_writable = ($urandom % 4) != 0; ent_nofault = ($urandom % 5) == 0;
      ent_side_effect = ($urandom % 4) == 0;
      apply("random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule